// File: doc/BRIEF.md
# Secondary-Side Error Status Register with Interrupt Mask

This block holds the sticky error flags for the secondary side of a bridge-style PCI Express port. The link logic delivers single-cycle event pulses: poisoned TLPs arriving, error messages sent, aborted or unsupported completions received or issued, and poisoned completions or writes. Each pulse sets one status flag under that flag's own gating rule. Two of those rules depend on the parity error response enable and the SERR enable. Once a flag is set it stays set until software clears it by writing a 1 to its bit position.

A second register holds one interrupt mask bit per error flag. Every mask bit is set after reset, so no error can interrupt until software unmasks it. The interrupt output is a registered OR of every flag whose mask bit is clear.

Software reaches both registers through a plain address and write-data port. The status register sits at configuration offset 0x1E. The mask register sits at an address given by a parameter. Reads return data combinationally from the stored state.

Top module: `err_stat_reg`

## Requirements
- R1: After reset the status register reads 0x0000, the mask register reads 0xF900 (bits 15, 14, 13, 12, 11 and 8 set) and the interrupt output is 0.
- R2: A poisoned-TLP-received pulse sets status bit 15 whatever the value of the parity error response enable.
- R3: An error-message-sent pulse sets status bit 14 only while the SERR enable is 1; while it is 0 the pulse has no effect.
- R4: A pulse for an Unsupported Request completion received sets bit 13. A pulse for a Completer Abort completion received sets bit 12. A pulse for a Completer Abort completion issued sets bit 11.
- R5: Bit 8 sets on a poisoned-completion-received pulse or a poisoned-write-issued pulse, but only while the parity error response enable is 1; while it is 0, bit 8 never sets.
- R6: Status bits are sticky. A write to the status address clears each defined bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R7: If a set pulse and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R8: Bits 10, 9 and 7 to 0 of both registers read as 0, and writes to them have no effect.
- R9: A write to the mask address loads the defined mask bits from the write data, and the mask reads back the stored value.
- R10: The interrupt output equals, one clock after the fact, the OR of all status bits whose mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_poison_tlp_rx | input | 1 | Poisoned TLP received on the secondary side |
| ev_err_msg_sent | input | 1 | ERR_FATAL or ERR_NONFATAL message sent |
| ev_ur_cpl_rx | input | 1 | Completion with Unsupported Request status received |
| ev_ca_cpl_rx | input | 1 | Completion with Completer Abort status received |
| ev_ca_cpl_sent | input | 1 | Completer Abort completion issued |
| ev_poison_cpl_rx | input | 1 | Requester received a poisoned completion |
| ev_poison_wr_sent | input | 1 | Requester poisoned a write request |
| cfg_par_resp_en | input | 1 | Parity error response enable |
| cfg_serr_en | input | 1 | SERR reporting enable |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register, 0 for other addresses |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest situation to reach is a collision: a set pulse and a write-1-to-clear land on the same bit in the same edge. The gated bits make it harder, because they must also collide while their enable is toggling. Directed steps force the collision on every defined bit and pulse the gated events with each enable both high and low. A long random phase with a fixed seed then mixes sparse event patterns, random enables and random writes to both registers and to unmapped addresses. After every edge it checks both read-backs and the one-cycle-delayed interrupt against a model kept in the bench.

// File: rtl/err_stat_pkg.sv
package err_stat_pkg;
  localparam int REG_W  = 16;
  localparam int B_DPE  = 15;
  localparam int B_SSE  = 14;
  localparam int B_RMA  = 13;
  localparam int B_RTA  = 12;
  localparam int B_STA  = 11;
  localparam int B_MDPE = 8;

  localparam logic [REG_W-1:0] DEF_BITS =
    (REG_W'(1) << B_DPE) | (REG_W'(1) << B_SSE) | (REG_W'(1) << B_RMA) |
    (REG_W'(1) << B_RTA) | (REG_W'(1) << B_STA) | (REG_W'(1) << B_MDPE);

  typedef struct packed {
    logic poison_tlp_rx;
    logic err_msg_sent;
    logic ur_cpl_rx;
    logic ca_cpl_rx;
    logic ca_cpl_sent;
    logic poison_cpl_rx;
    logic poison_wr_sent;
  } evt_t;

  function automatic logic [REG_W-1:0] gate_sets(evt_t e, logic par_en, logic serr_en);
    logic [REG_W-1:0] s;
    s = '0;
    s[B_DPE]  = e.poison_tlp_rx;
    s[B_SSE]  = e.err_msg_sent & serr_en;
    s[B_RMA]  = e.ur_cpl_rx;
    s[B_RTA]  = e.ca_cpl_rx;
    s[B_STA]  = e.ca_cpl_sent;
    s[B_MDPE] = par_en & (e.poison_cpl_rx | e.poison_wr_sent);
    return s;
  endfunction

  function automatic logic [REG_W-1:0] next_stat(logic [REG_W-1:0] cur,
                                                 logic [REG_W-1:0] set,
                                                 logic [REG_W-1:0] clr);
    return ((cur & ~clr) | set) & DEF_BITS;
  endfunction
endpackage

// File: rtl/err_evt_gate.sv
module err_evt_gate
  import err_stat_pkg::*;
(
  input  logic             rst_n,
  input  evt_t             ev,
  input  logic             par_en,
  input  logic             serr_en,
  output logic [REG_W-1:0] set_vec
);
  assign set_vec = gate_sets(ev, par_en, serr_en);

  always_comb begin
    if (rst_n) begin
      // R3
      serr_gate_chk: assert (serr_en || !set_vec[B_SSE]);
      // R5
      mdpe_gate_chk: assert (par_en || !set_vec[B_MDPE]);
      // R2
      dpe_ungated_chk: assert (!ev.poison_tlp_rx || set_vec[B_DPE]);
    end
  end
endmodule

// File: rtl/err_sticky_bits.sv
module err_sticky_bits
  import err_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic [REG_W-1:0] clr_vec,
  output logic [REG_W-1:0] stat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= next_stat(stat, set_vec, clr_vec);
  end

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((stat & $past(set_vec)) == $past(set_vec)));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && clr_vec == '0) |=> $stable(stat));
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((stat & $past(clr_vec & ~set_vec)) == '0));
endmodule

// File: rtl/err_mask_irq.sv
module err_mask_irq
  import err_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_we,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] stat,
  output logic [REG_W-1:0] mask,
  output logic             irq
);
  logic [REG_W-1:0] live_vec;
  assign live_vec = stat & ~mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= DEF_BITS;
      irq  <= 1'b0;
    end else begin
      if (mask_we) mask <= wdata & DEF_BITS;
      irq <= |live_vec;
    end
  end

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_vec == '0) |=> !irq);
  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_vec != '0) |=> irq);
endmodule

// File: rtl/err_stat_reg.sv
module err_stat_reg
  import err_stat_pkg::*;
#(
  parameter int AW = 12,
  parameter logic [AW-1:0] STAT_ADDR = 12'h01E,
  parameter logic [AW-1:0] MASK_ADDR = 12'h5A0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_poison_tlp_rx,
  input  logic          ev_err_msg_sent,
  input  logic          ev_ur_cpl_rx,
  input  logic          ev_ca_cpl_rx,
  input  logic          ev_ca_cpl_sent,
  input  logic          ev_poison_cpl_rx,
  input  logic          ev_poison_wr_sent,
  input  logic          cfg_par_resp_en,
  input  logic          cfg_serr_en,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic          irq
);
  evt_t             ev;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] stat;
  logic [REG_W-1:0] mask;
  logic             hit_stat;
  logic             hit_mask;

  assign ev = '{poison_tlp_rx: ev_poison_tlp_rx, err_msg_sent: ev_err_msg_sent,
                ur_cpl_rx: ev_ur_cpl_rx, ca_cpl_rx: ev_ca_cpl_rx,
                ca_cpl_sent: ev_ca_cpl_sent, poison_cpl_rx: ev_poison_cpl_rx,
                poison_wr_sent: ev_poison_wr_sent};

  assign hit_stat = (reg_addr == STAT_ADDR);
  assign hit_mask = (reg_addr == MASK_ADDR);
  assign clr_vec  = (reg_wr && hit_stat) ? (reg_wdata & DEF_BITS) : '0;

  err_evt_gate u_gate (
    .rst_n   (rst_n),
    .ev      (ev),
    .par_en  (cfg_par_resp_en),
    .serr_en (cfg_serr_en),
    .set_vec (set_vec)
  );

  err_sticky_bits u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .stat    (stat)
  );

  err_mask_irq u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_we (reg_wr && hit_mask),
    .wdata   (reg_wdata),
    .stat    (stat),
    .mask    (mask),
    .irq     (irq)
  );

  always_comb begin
    if (hit_stat)      reg_rdata = stat;
    else if (hit_mask) reg_rdata = mask;
    else               reg_rdata = '0;
  end

  // R9
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hit_mask) |=> (mask == ($past(reg_wdata) & DEF_BITS)));
endmodule

// File: tb/test_err_stat_reg.sv
module test_err_stat_reg;
  localparam int CLK_P = 10;
  localparam logic [11:0] A_STAT = 12'h01E;
  localparam logic [11:0] A_MASK = 12'h5A0;
  localparam logic [15:0] DEF = 16'hF900;

  logic clk = 0, rst_n = 0;
  logic [6:0] ev = '0;
  logic pe = 0, se = 0, wr = 0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic irq;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_stat, m_mask;
  logic m_irq;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  err_stat_reg i_err_stat_reg (
    .clk(clk), .rst_n(rst_n),
    .ev_poison_tlp_rx(ev[6]), .ev_err_msg_sent(ev[5]), .ev_ur_cpl_rx(ev[4]),
    .ev_ca_cpl_rx(ev[3]), .ev_ca_cpl_sent(ev[2]), .ev_poison_cpl_rx(ev[1]),
    .ev_poison_wr_sent(ev[0]), .cfg_par_resp_en(pe), .cfg_serr_en(se),
    .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq));

  function automatic logic [15:0] exp_sets(logic [6:0] e, logic p, logic s);
    logic [15:0] r = 16'h0000;
    if (e[6]) r = r | 16'h8000;
    if (e[5] && s) r = r | 16'h4000;
    if (e[4]) r = r | 16'h2000;
    if (e[3]) r = r | 16'h1000;
    if (e[2]) r = r | 16'h0800;
    if (p && (e[1] || e[0])) r = r | 16'h0100;
    return r;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic step(input logic [6:0] e, input logic p, input logic s,
                      input logic w, input logic [11:0] a, input logic [15:0] d);
    logic [15:0] clr;
    logic nirq;
    @(negedge clk);
    ev = e; pe = p; se = s; wr = w; addr = a; wdata = d;
    clr  = (w && a == A_STAT) ? (d & DEF) : 16'h0;
    nirq = (m_stat & ~m_mask) != 16'h0;
    for (int i = 0; i < 16; i++) begin
      if (exp_sets(e, p, s)[i]) m_stat[i] = 1'b1;
      else if (clr[i])          m_stat[i] = 1'b0;
    end
    if (w && a == A_MASK) m_mask = d & DEF;
    @(posedge clk);
    #1;
    m_irq = nirq;
    ev = '0; wr = 0;
  endtask

  task automatic check_all(string tag);
    logic [15:0] v;
    rd(A_STAT, v); chk({tag, " status"}, v, m_stat);
    rd(A_MASK, v); chk({tag, " mask"}, v, m_mask);
    chk({tag, " irq"}, {15'h0, irq}, {15'h0, m_irq});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd20240611));
    m_stat = 16'h0; m_mask = DEF; m_irq = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check_all("R1 reset");
    rd(12'h123, v); chk("R8 unmapped read", v, 16'h0);
    @(negedge clk); rst_n = 1;

    // R2 poisoned TLP with parity response off and on
    step(7'b1000000, 0, 0, 0, A_STAT, 0); check_all("R2 dpe pe=0");
    step(7'b0, 0, 0, 1, A_STAT, 16'h8000); check_all("R6 clear dpe");
    step(7'b1000000, 1, 0, 0, A_STAT, 0); check_all("R2 dpe pe=1");
    step(7'b0, 0, 0, 1, A_STAT, 16'hFFFF); check_all("R6 clear all");
    // R3 SERR gating
    step(7'b0100000, 1, 0, 0, A_STAT, 0); check_all("R3 sse blocked");
    step(7'b0100000, 0, 1, 0, A_STAT, 0); check_all("R3 sse set");
    // R4 completion status bits
    step(7'b0011100, 0, 0, 0, A_STAT, 0); check_all("R4 rma rta sta");
    step(7'b0, 0, 0, 1, A_STAT, 16'hFFFF); check_all("R6 clear");
    // R5 master data parity gating
    step(7'b0000011, 0, 1, 0, A_STAT, 0); check_all("R5 mdpe blocked");
    step(7'b0000010, 1, 0, 0, A_STAT, 0); check_all("R5 mdpe cpl");
    step(7'b0, 0, 0, 1, A_STAT, 16'h0100); check_all("R6 clear mdpe");
    step(7'b0000001, 1, 0, 0, A_STAT, 0); check_all("R5 mdpe wr");
    // R6 write of zeros keeps bits
    step(7'b1011100, 0, 0, 0, A_STAT, 0);
    step(7'b0, 0, 0, 1, A_STAT, 16'h0000); check_all("R6 write zero");
    step(7'b0, 0, 0, 1, A_STAT, 16'h2000); check_all("R6 partial clear");
    // R7 set beats clear on same bit
    step(7'b1111111, 1, 1, 1, A_STAT, 16'hFFFF); check_all("R7 collide all");
    chk("R7 all set", m_stat, DEF);
    step(7'b0000100, 0, 0, 1, A_STAT, 16'hFFFF); check_all("R7 collide sta");
    // R8 reserved bits
    step(7'b0, 0, 0, 1, A_MASK, 16'hFFFF); check_all("R8 mask reserved");
    step(7'b0, 0, 0, 1, A_STAT, 16'h06FF); check_all("R8 status reserved");
    // R9 mask write and R10 irq timing
    step(7'b0, 0, 0, 1, A_MASK, 16'h0000); check_all("R9 unmask all");
    step(7'b0, 0, 0, 1, A_STAT, 16'hFFFF); check_all("R10 irq after clear");
    step(7'b0, 0, 0, 0, A_STAT, 0); check_all("R10 irq drops");
    step(7'b0010000, 0, 0, 0, A_STAT, 0); check_all("R10 irq lags set");
    step(7'b0, 0, 0, 0, A_STAT, 0); check_all("R10 irq rises");
    step(7'b0, 0, 0, 1, A_MASK, 16'h2000); check_all("R9 mask one");
    step(7'b0, 0, 0, 0, A_STAT, 0); check_all("R10 masked off");

    // random phase: R6 R7 R9 R10
    for (int k = 0; k < 600; k++) begin
      logic [6:0] e;
      logic [11:0] a;
      logic [1:0] sel;
      e = 7'($urandom & $urandom & $urandom);
      sel = 2'($urandom);
      a = (sel == 0) ? 12'h3C4 : (sel[0] ? A_STAT : A_MASK);
      step(e, 1'($urandom), 1'($urandom), 1'($urandom), a, 16'($urandom));
      check_all("R10 random");
    end
    finish_run();
  end
endmodule